// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block sits in front of a voltage-output converter. It takes 16-bit command words from a three-wire serial link: an active-low frame select, a serial clock, and a data line. From each word it drives the converter's digital controls: a parallel straight-binary code, a two-bit output-stage mode, and an output-enable flag. It also gives a one-cycle strobe when a command takes effect.

The serial clock, the frame select and the data line are all sampled by a faster system clock. That clock runs at least four times the serial clock rate. Each serial input passes through two flops, and edges are found from the sampled values.

A frame opens on a falling frame select. One data bit, most significant first, is taken on each falling serial clock edge. The command acts on the sixteenth edge. If the frame select rises earlier, the frame is dropped. The top two bits of the word select the output-stage mode. The code field is left-justified just below them.

Top module: `serdac_frame_rx`

## Requirements
- R1: After reset, the code output is zero, the mode output is 00, the output-enable flag is high and the strobe is low.
- R2: A complete frame with word bits [15:14] = 00 loads the code output with word bits [13 : 14-CODE_W]. Bit 15 is shifted in first.
- R3: On a complete frame, the mode output takes word bits [15:14]. The encodings are 00 normal, 01 low-ohm ground tie, 10 high-ohm ground tie and 11 high impedance. The output-enable flag is high only when the mode is 00.
- R4: A complete frame whose mode bits are not 00 changes only the mode. The code output keeps its previous value.
- R5: If the frame select rises before the sixteenth falling serial clock edge, the frame is discarded. The code and mode do not change and no strobe is given. The next frame is decoded from its own bits only.
- R6: Falling serial clock edges after the sixteenth in the same frame are ignored until the frame select has gone high and fallen again.
- R7: The strobe is high for exactly one system clock cycle for each complete frame, and at no other time.
- R8: Word bits below the code field (bits [13-CODE_W:0]) have no effect on any output.
- R9: The frame select may stay low after the sixteenth edge. A new frame then starts only on its next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock; data is taken on its falling edge |
| csn_in | input | 1 | Active-low frame select |
| sdi_in | input | 1 | Serial data, most significant bit first |
| dac_code | output | CODE_W | Straight-binary converter code |
| pd_mode | output | 2 | Output-stage mode (00 normal, 01/10/11 power-down variants) |
| out_en | output | 1 | High when the output amplifier drives the pin |
| upd_strobe | output | 1 | One-cycle pulse when a command takes effect |

## Verification
Normal-mode words with alternating, all-ones and sparse bit patterns check that the code field lands in the right bit positions with the most significant bit first. All-ones and all-zero values in the ignored low bits show that they have no effect. Each of the three power-down encodings is sent with a data field that differs from the held code, which shows that the mode changes while the code is kept. A frame cut short after ten bits, followed by a full frame, shows that the discard works and that no leftover bits remain. A frame followed by eight extra clock edges, with the frame select kept low, shows that surplus bits are ignored until a new frame begins. Strobe pulses are counted and their widths measured on every scenario.

// File: rtl/serdac_frame_rx.sv
module serdac_frame_rx #(
  parameter int CODE_W  = 12,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              csn_in,
  input  logic              sdi_in,
  output logic [CODE_W-1:0] dac_code,
  output logic [1:0]        pd_mode,
  output logic              out_en,
  output logic              upd_strobe
);
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int CODE_HI = FRAME_W - 3;

  logic [1:0] sclk_ff, csn_ff, sdi_ff;
  logic       sclk_d, csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_ff <= 2'b00;
      csn_ff  <= 2'b11;
      sdi_ff  <= 2'b00;
      sclk_d  <= 1'b0;
      csn_d   <= 1'b1;
    end else begin
      sclk_ff <= {sclk_ff[0], sclk_in};
      csn_ff  <= {csn_ff[0], csn_in};
      sdi_ff  <= {sdi_ff[0], sdi_in};
      sclk_d  <= sclk_ff[1];
      csn_d   <= csn_ff[1];
    end
  end

  wire sclk_s    = sclk_ff[1];
  wire csn_s     = csn_ff[1];
  wire sdi_s     = sdi_ff[1];
  wire sclk_fall = sclk_d & ~sclk_s;
  wire csn_fall  = csn_d & ~csn_s;

  logic                 armed;
  logic [CNT_W-1:0]     bit_cnt;
  logic [FRAME_W-2:0]   shreg;
  logic [FRAME_W-1:0]   shift_nxt;
  logic                 last_bit;

  assign shift_nxt = {shreg, sdi_s};
  assign last_bit  = armed & sclk_fall & (bit_cnt == CNT_W'(FRAME_W - 1));
  assign out_en    = (pd_mode == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      dac_code   <= '0;
      pd_mode    <= 2'b00;
      upd_strobe <= 1'b0;
    end else begin
      upd_strobe <= 1'b0;
      if (csn_s) begin
        armed   <= 1'b0;
        bit_cnt <= '0;
        shreg   <= '0;
      end else if (csn_fall) begin
        armed   <= 1'b1;
        bit_cnt <= '0;
        shreg   <= '0;
      end else if (armed && sclk_fall) begin
        shreg   <= shift_nxt[FRAME_W-2:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (last_bit) begin
          armed      <= 1'b0;
          upd_strobe <= 1'b1;
          pd_mode    <= shift_nxt[FRAME_W-1 -: 2];
          if (shift_nxt[FRAME_W-1 -: 2] == 2'b00)
            dac_code <= shift_nxt[CODE_HI -: CODE_W];
        end
      end
    end
  end

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> !upd_strobe);

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> upd_strobe);

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_mode) |-> upd_strobe);

  // R4
  pd_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && pd_mode != 2'b00) |-> $stable(dac_code));

  // R5
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> $past(!csn_s));
endmodule

// File: tb/serdac_frame_rx_tb.sv
module serdac_frame_rx_tb;
  localparam int CW = 12;

  logic clk = 0, rst_n = 0, sclk = 0, csn = 1, sdi = 0;
  logic [CW-1:0] dac_code;
  logic [1:0] pd_mode;
  logic out_en, upd_strobe;

  int checks = 0, errors = 0;
  int pulses = 0, wide = 0;
  logic strobe_prev = 0;
  logic [CW-1:0] held;

  always #2.5 clk = ~clk;

  serdac_frame_rx #(.CODE_W(CW), .FRAME_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .csn_in(csn), .sdi_in(sdi),
    .dac_code(dac_code), .pd_mode(pd_mode), .out_en(out_en), .upd_strobe(upd_strobe));

  always @(negedge clk) begin
    if (upd_strobe && !strobe_prev) pulses++;
    if (upd_strobe && strobe_prev) wide++;
    strobe_prev <= upd_strobe;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: run did not end (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] field(input logic [15:0] w);
    return CW'(w >> (14 - CW));
  endfunction

  task automatic clock_bits(input logic [15:0] w, input int n);
    for (int i = 15; i > 15 - n; i--) begin
      sdi = w[i]; sclk = 1; #20; sclk = 0; #20;
    end
  endtask

  task automatic send(input logic [15:0] w, input int n, input bit keep_low);
    csn = 0; #20;
    clock_bits(w, n);
    #20;
    if (!keep_low) begin csn = 1; #40; end
  endtask

  task automatic t_reset;
    chk("R1 code", dac_code, 0);
    chk("R1 mode", pd_mode, 0);
    chk("R1 out_en", out_en, 1);
    chk("R1 strobe", pulses, 0);
  endtask

  task automatic t_normal(input logic [15:0] w);
    int p0 = pulses;
    send(w, 16, 0);
    chk("R2 code", dac_code, field(w));
    chk("R3 mode normal", pd_mode, 0);
    chk("R3 out_en", out_en, 1);
    chk("R7 one pulse", pulses - p0, 1);
  endtask

  task automatic t_lowbits;
    send(16'h3FFF, 16, 0);
    chk("R8 all ones", dac_code, field(16'h3FFF));
    send(16'h0003, 16, 0);
    chk("R8 low bits ignored", dac_code, 0);
    send(16'h1234 | 16'h0003, 16, 0);
    chk("R8 low bits set", dac_code, field(16'h1234));
  endtask

  task automatic t_powerdown;
    held = dac_code;
    for (int m = 1; m < 4; m++) begin
      send({2'(m), 14'h1555 ^ 14'(m)}, 16, 0);
      chk("R3 mode", pd_mode, m);
      chk("R3 out_en off", out_en, 0);
      chk("R4 code kept", dac_code, held);
    end
    send(16'h0A5C, 16, 0);
    chk("R3 back to normal", pd_mode, 0);
    chk("R2 code after wake", dac_code, field(16'h0A5C));
  endtask

  task automatic t_abort;
    int p0 = pulses;
    held = dac_code;
    send(16'hFFFF, 10, 0);
    chk("R5 code kept", dac_code, held);
    chk("R5 mode kept", pd_mode, 0);
    chk("R5 no pulse", pulses - p0, 0);
    send(16'h1111, 16, 0);
    chk("R5 clean next frame", dac_code, field(16'h1111));
    chk("R5 next frame mode", pd_mode, 0);
  endtask

  task automatic t_extra;
    int p0 = pulses;
    send(16'h2468, 16, 1);
    clock_bits(16'hFFFF, 8);
    #40;
    chk("R6 extra edges ignored", dac_code, field(16'h2468));
    chk("R9 held low mode", pd_mode, 0);
    chk("R6 single pulse", pulses - p0, 1);
    csn = 1; #40;
    send(16'h0FF0, 16, 0);
    chk("R9 new frame after rise", dac_code, field(16'h0FF0));
  endtask

  initial begin
    #12 rst_n = 1;
    @(negedge clk); #20;
    t_reset();
    t_normal(16'h2AB4);
    t_normal(16'h1001);
    t_lowbits();
    t_powerdown();
    t_abort();
    t_extra();
    #40;
    chk("R7 width", wide, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule